// File: doc/BRIEF.md
# Microcode Sequencer with Encoded Next-Address Types

This block is the control half of a small microprogrammed processor. A micro-program counter selects one word of a constant microcode store held inside the block. Each word drives an 18-line control vector toward a datapath. Each word also holds a 3-bit next-address type instead of a full successor address. A jump stage resolves that type from the current micro-address, the macro-instruction opcode, a memory-busy flag and a condition flag.

The stored program runs a shared three-step fetch routine. The routine dispatches on the 5-bit opcode into one of six instruction routines or an illegal-opcode routine, and every routine ends by returning to fetch. The control vector comes combinationally from the current word. The micro-address is registered, so a change on any input reaches the micro-address one clock later.

Top module: `mseq_top`

## Requirements
- R1: While `rst_ni` is low the micro-address is 0 (asynchronously). After release it stays 0 for two more rising edges, and advances on the third.
- R2: A step of type next moves the micro-address to its value plus one. The fetch routine is 0 (next), 1 (spin), 2 (dispatch).
- R3: A step of type spin holds the micro-address while `busy_i` is 1 and moves to its value plus one on the first edge with `busy_i` at 0. Steps 1 and 12 are spin steps.
- R4: A step of type fetch moves the micro-address to 0. Routines end in fetch at 5, 8, 13, 19, 23, 28 and 29.
- R5: Dispatch at step 2 jumps by opcode: 0x0C to 3, 0x04 to 6, 0x00 to 9, 0x18 to 14, 0x1B to 20, 0x0A to 24. Each routine then runs through consecutive addresses.
- R6: Any other opcode dispatches to 29, which returns to 0 on the next edge.
- R7: Step 16 is ffalse: with `cond_i` 0 it goes to 0, with `cond_i` 1 it goes to 17.
- R8: Step 26 is ftrue: with `cond_i` 1 it goes to 0, with `cond_i` 0 it goes to 27.
- R9: The control vector is 0x00023 at address 0, 0x00208 at address 1, 0x30110 at address 2, and 0 at address 29.
- R10: `busy_i` and `cond_i` have no effect on next-type steps: they advance by one whatever those inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode_i | input | OPC_W (5) | Macro-instruction opcode used at dispatch |
| cond_i | input | 1 | Datapath condition flag for conditional fetch steps |
| busy_i | input | 1 | Memory busy flag for spin steps |
| ctl_o | output | 18 | Datapath control lines from the current microcode word |
| upc_o | output | UPC_W (6) | Current micro-address |

## Verification
The bench builds the block with its default widths: a 6-bit micro-address and a 5-bit opcode. These widths put every routine, both conditional exits, the illegal-opcode path and the two spin points within reach of directed runs. Spin steps are held for several busy cycles. Both values of the condition flag are driven at each conditional step. A reset is applied in mid-routine to exercise the asynchronous entry and the two-edge release.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    JT_NEXT   = 3'd0,
    JT_SPIN   = 3'd1,
    JT_FETCH  = 3'd2,
    JT_DISP   = 3'd3,
    JT_FTRUE  = 3'd4,
    JT_FFALSE = 3'd5
  } jt_e;

  typedef enum logic [1:0] {RS_PC = 2'd0, RS_RS1 = 2'd1, RS_RS2 = 2'd2, RS_RD = 2'd3} rsel_e;
  typedef enum logic [1:0] {AL_ADD = 2'd0, AL_DEC4 = 2'd1, AL_FUNC = 2'd2, AL_INC4 = 2'd3} alu_e;
  typedef enum logic [2:0] {IM_I = 3'd0, IM_B = 3'd1, IM_J = 3'd2} isel_e;

  // control vector, bit 0 is ma_ld
  typedef struct packed {
    alu_e  alu_op;   // 17:16
    isel_e imm_sel;  // 15:13
    rsel_e reg_sel;  // 12:11
    logic  mem_wr;   // 10
    logic  mem_en;   // 9
    logic  alu_en;   // 8
    logic  imm_en;   // 7
    logic  reg_wr;   // 6
    logic  reg_en;   // 5
    logic  pc_ld;    // 4
    logic  ir_ld;    // 3
    logic  b_ld;     // 2
    logic  a_ld;     // 1
    logic  ma_ld;    // 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  typedef struct packed {
    jt_e  jt;
    ctl_t ctl;
  } uword_t;

  // routine entry points
  localparam int A_FETCH0 = 0;
  localparam int A_ALU    = 3;
  localparam int A_ALUI   = 6;
  localparam int A_LOAD   = 9;
  localparam int A_BR     = 14;
  localparam int A_JAL    = 20;
  localparam int A_SKIP   = 24;
  localparam int A_ILL    = 29;

  // opcode groups
  localparam int OP_ALU  = 'h0C;
  localparam int OP_ALUI = 'h04;
  localparam int OP_LOAD = 'h00;
  localparam int OP_BR   = 'h18;
  localparam int OP_JAL  = 'h1B;
  localparam int OP_SKIP = 'h0A;

  function automatic ctl_t f_reg2a(rsel_e s);
    ctl_t c = '0;
    c.reg_en  = 1'b1;
    c.reg_sel = s;
    c.a_ld    = 1'b1;
    return c;
  endfunction

  function automatic ctl_t f_reg2b(rsel_e s);
    ctl_t c = '0;
    c.reg_en  = 1'b1;
    c.reg_sel = s;
    c.b_ld    = 1'b1;
    return c;
  endfunction

  function automatic ctl_t f_imm2b(isel_e s);
    ctl_t c = '0;
    c.imm_en  = 1'b1;
    c.imm_sel = s;
    c.b_ld    = 1'b1;
    return c;
  endfunction

  function automatic ctl_t f_alu(alu_e op);
    ctl_t c = '0;
    c.alu_en = 1'b1;
    c.alu_op = op;
    return c;
  endfunction

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic [UPC_W-1:0] addr_i,
  output uword_t           word_o
);

  ctl_t c;
  jt_e  j;

  always_comb begin
    c = '0;
    j = JT_FETCH;
    case (int'(addr_i))
      A_FETCH0:     begin c = f_reg2a(RS_PC); c.ma_ld = 1'b1; j = JT_NEXT; end
      A_FETCH0 + 1: begin c.mem_en = 1'b1; c.ir_ld = 1'b1; j = JT_SPIN; end
      A_FETCH0 + 2: begin c = f_alu(AL_INC4); c.pc_ld = 1'b1; j = JT_DISP; end
      // register-register
      A_ALU:        begin c = f_reg2a(RS_RS1); j = JT_NEXT; end
      A_ALU + 1:    begin c = f_reg2b(RS_RS2); j = JT_NEXT; end
      A_ALU + 2:    begin c = f_alu(AL_FUNC); c.reg_en = 1'b1; c.reg_wr = 1'b1;
                          c.reg_sel = RS_RD; j = JT_FETCH; end
      // register-immediate
      A_ALUI:       begin c = f_reg2a(RS_RS1); j = JT_NEXT; end
      A_ALUI + 1:   begin c = f_imm2b(IM_I); j = JT_NEXT; end
      A_ALUI + 2:   begin c = f_alu(AL_FUNC); c.reg_en = 1'b1; c.reg_wr = 1'b1;
                          c.reg_sel = RS_RD; j = JT_FETCH; end
      // load
      A_LOAD:       begin c = f_reg2a(RS_RS1); j = JT_NEXT; end
      A_LOAD + 1:   begin c = f_imm2b(IM_I); j = JT_NEXT; end
      A_LOAD + 2:   begin c = f_alu(AL_ADD); c.ma_ld = 1'b1; j = JT_NEXT; end
      A_LOAD + 3:   begin c.mem_en = 1'b1; c.reg_en = 1'b1; c.reg_wr = 1'b1;
                          c.reg_sel = RS_RD; j = JT_SPIN; end
      A_LOAD + 4:   begin j = JT_FETCH; end
      // branch, falls to fetch when not taken
      A_BR:         begin c = f_reg2a(RS_RS1); j = JT_NEXT; end
      A_BR + 1:     begin c = f_reg2b(RS_RS2); j = JT_NEXT; end
      A_BR + 2:     begin c = f_reg2a(RS_PC); j = JT_FFALSE; end
      A_BR + 3:     begin c = f_alu(AL_DEC4); c.a_ld = 1'b1; j = JT_NEXT; end
      A_BR + 4:     begin c = f_imm2b(IM_B); j = JT_NEXT; end
      A_BR + 5:     begin c = f_alu(AL_ADD); c.pc_ld = 1'b1; j = JT_FETCH; end
      // jump and link
      A_JAL:        begin c.reg_en = 1'b1; c.reg_wr = 1'b1; c.reg_sel = RS_RD; j = JT_NEXT; end
      A_JAL + 1:    begin c = f_alu(AL_DEC4); c.a_ld = 1'b1; j = JT_NEXT; end
      A_JAL + 2:    begin c = f_imm2b(IM_J); j = JT_NEXT; end
      A_JAL + 3:    begin c = f_alu(AL_ADD); c.pc_ld = 1'b1; j = JT_FETCH; end
      // inverted-sense branch, falls to fetch when condition holds
      A_SKIP:       begin c = f_reg2a(RS_RS1); j = JT_NEXT; end
      A_SKIP + 1:   begin c = f_reg2b(RS_RS2); j = JT_NEXT; end
      A_SKIP + 2:   begin c = f_reg2a(RS_PC); j = JT_FTRUE; end
      A_SKIP + 3:   begin c = f_imm2b(IM_B); j = JT_NEXT; end
      A_SKIP + 4:   begin c = f_alu(AL_ADD); c.pc_ld = 1'b1; j = JT_FETCH; end
      // illegal opcode: no datapath action
      A_ILL:        begin j = JT_FETCH; end
      default:      begin j = JT_FETCH; end
    endcase
  end

  assign word_o = '{jt: j, ctl: c};

endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
#(
  parameter int UPC_W = 6,
  parameter int OPC_W = 5
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UPC_W-1:0] start_o
);

  always_comb begin
    case (opcode_i)
      OPC_W'(OP_ALU):  start_o = UPC_W'(A_ALU);
      OPC_W'(OP_ALUI): start_o = UPC_W'(A_ALUI);
      OPC_W'(OP_LOAD): start_o = UPC_W'(A_LOAD);
      OPC_W'(OP_BR):   start_o = UPC_W'(A_BR);
      OPC_W'(OP_JAL):  start_o = UPC_W'(A_JAL);
      OPC_W'(OP_SKIP): start_o = UPC_W'(A_SKIP);
      default:         start_o = UPC_W'(A_ILL);
    endcase
  end

endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic [UPC_W-1:0] upc_i,
  input  jt_e              jt_i,
  input  logic             busy_i,
  input  logic             cond_i,
  input  logic [UPC_W-1:0] disp_i,
  output logic [UPC_W-1:0] upc_nxt_o,
  output logic             upc_en_o
);

  localparam logic [UPC_W-1:0] FETCH_ADDR = UPC_W'(A_FETCH0);

  logic [UPC_W-1:0] upc_inc;
  assign upc_inc = upc_i + 1'b1;

  always_comb begin
    upc_en_o  = 1'b1;
    upc_nxt_o = upc_inc;
    case (jt_i)
      JT_NEXT:   upc_nxt_o = upc_inc;
      JT_SPIN:   upc_en_o  = !busy_i;
      JT_FETCH:  upc_nxt_o = FETCH_ADDR;
      JT_DISP:   upc_nxt_o = disp_i;
      JT_FTRUE:  upc_nxt_o = cond_i ? FETCH_ADDR : upc_inc;
      JT_FFALSE: upc_nxt_o = cond_i ? upc_inc : FETCH_ADDR;
      default:   upc_nxt_o = FETCH_ADDR;
    endcase
  end

endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int UPC_W = 6,
  parameter int OPC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             cond_i,
  input  logic             busy_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [UPC_W-1:0] upc_o
);

  logic             rst_meta_q;
  logic             rst_q_n;
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic             upc_en;
  logic [UPC_W-1:0] disp_addr;
  uword_t           word;
  jt_e              jt_cur;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  mseq_rom #(.UPC_W(UPC_W)) rom_i (
    .addr_i (upc_q),
    .word_o (word)
  );

  mseq_decode #(.UPC_W(UPC_W), .OPC_W(OPC_W)) dec_i (
    .opcode_i (opcode_i),
    .start_o  (disp_addr)
  );

  assign jt_cur = word.jt;

  mseq_next #(.UPC_W(UPC_W)) nxt_i (
    .upc_i     (upc_q),
    .jt_i      (jt_cur),
    .busy_i    (busy_i),
    .cond_i    (cond_i),
    .disp_i    (disp_addr),
    .upc_nxt_o (upc_nxt),
    .upc_en_o  (upc_en)
  );

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      upc_q <= UPC_W'(A_FETCH0);
    end else if (upc_en) begin
      upc_q <= upc_nxt;
    end
  end

  assign ctl_o = word.ctl;
  assign upc_o = upc_q;

endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
  import mseq_pkg::*;
#(
  parameter int UPC_W = 6,
  parameter int OPC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic [UPC_W-1:0] upc,
  input jt_e              jt,
  input logic             busy,
  input logic             cond,
  input logic [OPC_W-1:0] opcode,
  input logic [CTL_W-1:0] ctl
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_fetch0_R1: assert (upc == UPC_W'(A_FETCH0))
        else $error("micro-address not at fetch0 during reset");
    end
  end

  assert_next_inc_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_NEXT) |=> (upc == UPC_W'($past(upc) + 1'b1)));

  assert_spin_hold_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_SPIN && busy) |=> $stable(upc));

  assert_spin_go_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_SPIN && !busy) |=> (upc == UPC_W'($past(upc) + 1'b1)));

  assert_fetch_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_FETCH) |=> (upc == UPC_W'(A_FETCH0)));

  assert_disp_alu_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_DISP && opcode == OPC_W'(OP_ALU)) |=> (upc == UPC_W'(A_ALU)));

  assert_illegal_back_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && upc == UPC_W'(A_ILL)) |=> (upc == UPC_W'(A_FETCH0)));

  assert_ffalse_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_FFALSE && !cond) |=> (upc == UPC_W'(A_FETCH0)));

  assert_ftrue_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rst_q_n && jt == JT_FTRUE && cond) |=> (upc == UPC_W'(A_FETCH0)));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upc == UPC_W'(A_ILL)) |-> (ctl == '0));

endmodule

bind mseq_top mseq_chk #(.UPC_W(UPC_W), .OPC_W(OPC_W)) chk_i (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .rst_q_n (rst_q_n),
  .upc     (upc_q),
  .jt      (jt_cur),
  .busy    (busy_i),
  .cond    (cond_i),
  .opcode  (opcode_i),
  .ctl     (ctl_o)
);

// File: tb/mseq_top_tb_top.sv
module mseq_top_tb_top;

  localparam int CW = 18;

  logic          clk;
  logic          rst_n;
  logic [4:0]    opc;
  logic          cond;
  logic          busy;
  logic [CW-1:0] ctl;
  logic [5:0]    upc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  mseq_top dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .opcode_i (opc),
    .cond_i   (cond),
    .busy_i   (busy),
    .ctl_o    (ctl),
    .upc_o    (upc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_upc(int exp, string tag);
    checks++;
    if (upc !== 6'(exp)) begin
      errors++;
      $display("FAIL %s: upc=%0d expected %0d", tag, upc, exp);
    end
  endtask

  task automatic chk_ctl(logic [CW-1:0] exp, string tag);
    checks++;
    if (ctl !== exp) begin
      errors++;
      $display("FAIL %s: ctl=%05h expected %05h", tag, ctl, exp);
    end
  endtask

  task automatic walk(int from, int to, string tag);
    for (int a = from + 1; a <= to; a++) begin
      step();
      chk_upc(a, tag);
    end
  endtask

  // fetch routine with nbusy held cycles, ending on the dispatch target
  task automatic do_fetch(logic [4:0] op, int nbusy, int start);
    chk_upc(0, "R2 fetch0");
    chk_ctl(18'h00023, "R9 fetch0 lines");
    busy = 1'b0;
    step();
    chk_upc(1, "R2 fetch1");
    chk_ctl(18'h00208, "R9 fetch1 lines");
    busy = 1'b1;
    for (int i = 0; i < nbusy; i++) begin
      step();
      chk_upc(1, "R3 spin hold");
    end
    busy = 1'b0;
    opc  = op;
    step();
    chk_upc(2, "R3 spin release");
    chk_ctl(18'h30110, "R9 fetch2 lines");
    step();
    chk_upc(start, "R5 dispatch");
  endtask

  task automatic t_reset();
    rst_n = 1'b1;
    opc   = '0;
    cond  = 1'b0;
    busy  = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_upc(0, "R1 in reset");
    chk_ctl(18'h00023, "R1 fetch0 word in reset");
    rst_n = 1'b1;
    step();
    chk_upc(0, "R1 release edge 1");
    step();
    chk_upc(0, "R1 release edge 2");
  endtask

  task automatic t_alu();
    do_fetch(5'h0C, 2, 3);
    busy = 1'b1;
    cond = 1'b1;
    walk(3, 5, "R10 next ignores busy and cond");
    busy = 1'b0;
    cond = 1'b0;
    step();
    chk_upc(0, "R4 return after alu");
  endtask

  task automatic t_alui();
    do_fetch(5'h04, 0, 6);
    walk(6, 8, "R2 alui");
    step();
    chk_upc(0, "R4 return after alui");
  endtask

  task automatic t_load();
    do_fetch(5'h00, 1, 9);
    walk(9, 12, "R2 load");
    busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk_upc(12, "R3 load spin hold");
    end
    busy = 1'b0;
    step();
    chk_upc(13, "R3 load spin release");
    step();
    chk_upc(0, "R4 return after load");
  endtask

  task automatic t_branch(logic c);
    do_fetch(5'h18, 0, 14);
    walk(14, 16, "R2 branch");
    cond = c;
    step();
    if (!c) begin
      chk_upc(0, "R7 ffalse to fetch");
    end else begin
      chk_upc(17, "R7 ffalse falls through");
      cond = 1'b0;
      walk(17, 19, "R2 branch taken");
      step();
      chk_upc(0, "R4 return after branch");
    end
    cond = 1'b0;
  endtask

  task automatic t_jal();
    do_fetch(5'h1B, 0, 20);
    walk(20, 23, "R2 jal");
    step();
    chk_upc(0, "R4 return after jal");
  endtask

  task automatic t_skip(logic c);
    do_fetch(5'h0A, 1, 24);
    walk(24, 26, "R2 skip");
    cond = c;
    step();
    if (c) begin
      chk_upc(0, "R8 ftrue to fetch");
    end else begin
      chk_upc(27, "R8 ftrue falls through");
      walk(27, 28, "R2 skip tail");
      step();
      chk_upc(0, "R4 return after skip");
    end
    cond = 1'b0;
  endtask

  task automatic t_illegal(logic [4:0] op);
    do_fetch(op, 0, 29);
    chk_ctl('0, "R9 illegal routine lines");
    step();
    chk_upc(0, "R6 illegal returns to fetch");
  endtask

  task automatic t_mid_reset();
    do_fetch(5'h0C, 0, 3);
    step();
    chk_upc(4, "R2 before mid reset");
    #1 rst_n = 1'b0;
    #1 chk_upc(0, "R1 asynchronous entry");
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step();
    chk_upc(0, "R1 mid release edge 1");
    step();
    chk_upc(0, "R1 mid release edge 2");
    step();
    chk_upc(1, "R1 advances on third edge");
    step();
    chk_upc(2, "R3 fetch1 not busy");
    opc = 5'h04;
    step();
    chk_upc(6, "R5 dispatch after reset");
    walk(6, 8, "R2 alui after reset");
    step();
    chk_upc(0, "R4 return after reset run");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu();
    t_alui();
    t_load();
    t_branch(1'b0);
    t_branch(1'b1);
    t_jal();
    t_skip(1'b1);
    t_skip(1'b0);
    t_illegal(5'h1F);
    t_illegal(5'h01);
    t_illegal(5'h0B);
    t_mid_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule